// File: doc/BRIEF.md
# Peripheral Bus Clock Scaler and Access Bridge

This block derives a clock-enable for a slower peripheral bus from the system clock. The ratio is set by a two-bit divisor field in a control register and can be 1:1, 1:2, 1:4 or 1:8. Peripherals on the divided bus advance only in cycles where the enable is high. Every one of them follows the same enable, so a change of divisor reaches all of them at once.

The block also bridges a system-clock request/ready port from the CPU to those peripherals. The CPU holds its request until ready. The bridge issues the peripheral strobe only in a cycle where the divided-clock enable is high, and it returns ready in that same cycle. Access latency therefore depends on the divisor and on the divider phase when the request arrives. Reads and writes use the same handshake.

A new divisor is picked up only at a divided-clock edge. The period in progress always runs to its full old length, so no enable gap is ever cut short.

Top module: `periph_clk_bridge`

## Requirements
- R1: After reset the divisor field is 00, the control register reads as zero, the enable is high in the first cycle, and no strobe or ready is given without a request.
- R2: With divisor code n (00 gives 1:1, 01 gives 1:2, 10 gives 1:4, 11 gives 1:8), enable pulses are exactly 2^n system cycles apart, and each pulse lasts one cycle when n is above zero.
- R3: With code 00 the enable stays high in every cycle, and a request is answered with ready in the same cycle it is raised.
- R4: The divisor field reads back at control-register bits 20:19. All other bits read as zero, and writing them has no effect.
- R5: A divisor written in cycle t governs every period that begins at an enable pulse after cycle t. The period running at cycle t finishes at its old length, including when t is itself a pulse cycle.
- R6: The peripheral strobe is high only in cycles where both the enable and the request are high, and ready equals the strobe in every cycle.
- R7: A request raised in some cycle receives ready in the first cycle at or after it with the enable high. At 1:8 this gives a wait of 0 to 7 cycles, depending on phase.
- R8: In the strobe cycle the peripheral write flag, address and write data equal the CPU's. The CPU read data equals the peripheral read data in a read's ready cycle and is zero otherwise.
- R9: A request held high across several enable pulses is answered once at every pulse, and at no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWe | input | 1 | Control register write enable |
| ctlWdata | input | 32 | Control register write data (divisor at 20:19) |
| ctlRdata | output | 32 | Control register read value |
| cpuReq | input | 1 | CPU access request, held until ready |
| cpuWe | input | 1 | CPU access is a write |
| cpuAddr | input | AW | CPU access address |
| cpuWdata | input | DW | CPU write data |
| cpuRdy | output | 1 | Access completes in this cycle |
| cpuRdata | output | DW | Read data, valid with ready on a read |
| pClkEn | output | 1 | Divided peripheral clock enable |
| pStb | output | 1 | Peripheral access strobe |
| pWe | output | 1 | Peripheral write flag |
| pAddr | output | AW | Peripheral address |
| pWdata | output | DW | Peripheral write data |
| pRdata | input | DW | Peripheral read data |

## Verification
Two things can land in one cycle: a divisor write and an enable pulse that completes a CPU access. The bench sets this up from a 1:1 ratio, where every cycle is a pulse. In that cycle it writes the 1:4 code while a read request is pending. It then expects ready and the correct data in that cycle, one more pulse in the following cycle at the old length, and only after that pulses four cycles apart. It also writes a new code two cycles into a 1:8 period and checks that this period still ends at its full eight cycles.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  // divisor field width and the phase counter it implies (max ratio - 1)
  localparam int DIV_W = 2;
  localparam int CNT_W = (1 << DIV_W) - 1;

  typedef struct packed {
    logic issue;    // access completes this cycle
    logic loadDiv;  // control register write
  } ctlStrobes_t;
endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
  import pcb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             ctlWe,
  input  logic [DIV_W-1:0] divCode,
  output logic             pClkEn,
  output ctlStrobes_t      strb
);
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] reload;

  // cycles left in a new period: ratio minus one
  always_comb reload = CNT_W'((32'd1 << divCode) - 32'd1);

  // divisor is sampled only when a period starts, so gaps are never shortened
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (phaseCnt == '0)  phaseCnt <= reload;
    else                      phaseCnt <= phaseCnt - 1'b1;
  end

  assign pClkEn = (phaseCnt == '0);

  always_comb begin
    strb.issue   = cpuReq & pClkEn;
    strb.loadDiv = ctlWe;
  end
endmodule

// File: rtl/pcb_dpath.sv
module pcb_dpath
  import pcb_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int DIV_LSB = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [DIV_W-1:0] divIn,
  input  logic             cpuWe,
  input  logic [AW-1:0]    cpuAddr,
  input  logic [DW-1:0]    cpuWdata,
  input  logic [DW-1:0]    pRdata,
  output logic [DIV_W-1:0] divCode,
  output logic [31:0]      ctlRdata,
  output logic             pStb,
  output logic             pWe,
  output logic [AW-1:0]    pAddr,
  output logic [DW-1:0]    pWdata,
  output logic             cpuRdy,
  output logic [DW-1:0]    cpuRdata
);
  logic [DIV_W-1:0] divReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             divReg <= '0;
    else if (strb.loadDiv) divReg <= divIn;
  end

  assign divCode = divReg;

  always_comb begin
    ctlRdata = '0;
    ctlRdata[DIV_LSB +: DIV_W] = divReg;
  end

  // peripheral side follows the CPU side, qualified by the issue strobe
  assign pStb     = strb.issue;
  assign pWe      = strb.issue & cpuWe;
  assign pAddr    = cpuAddr;
  assign pWdata   = cpuWdata;
  assign cpuRdy   = strb.issue;
  assign cpuRdata = (strb.issue && !cpuWe) ? pRdata : '0;
endmodule

// File: rtl/periph_clk_bridge.sv
module periph_clk_bridge
  import pcb_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int DIV_LSB = 19
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlWe,
  input  logic [31:0]   ctlWdata,
  output logic [31:0]   ctlRdata,
  input  logic          cpuReq,
  input  logic          cpuWe,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuRdy,
  output logic [DW-1:0] cpuRdata,
  output logic          pClkEn,
  output logic          pStb,
  output logic          pWe,
  output logic [AW-1:0] pAddr,
  output logic [DW-1:0] pWdata,
  input  logic [DW-1:0] pRdata
);
  ctlStrobes_t      strb;
  logic [DIV_W-1:0] divCode;

  pcb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .ctlWe   (ctlWe),
    .divCode (divCode),
    .pClkEn  (pClkEn),
    .strb    (strb)
  );

  pcb_dpath #(.AW(AW), .DW(DW), .DIV_LSB(DIV_LSB)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .divIn    (ctlWdata[DIV_LSB +: DIV_W]),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .pRdata   (pRdata),
    .divCode  (divCode),
    .ctlRdata (ctlRdata),
    .pStb     (pStb),
    .pWe      (pWe),
    .pAddr    (pAddr),
    .pWdata   (pWdata),
    .cpuRdy   (cpuRdy),
    .cpuRdata (cpuRdata)
  );
endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int AW      = 8,
  parameter int DIV_LSB = 19
) (
  input logic          clk,
  input logic          rstN,
  input logic [31:0]   ctlRdata,
  input logic          cpuReq,
  input logic          cpuWe,
  input logic [AW-1:0] cpuAddr,
  input logic          cpuRdy,
  input logic          pClkEn,
  input logic          pStb,
  input logic          pWe,
  input logic [AW-1:0] pAddr
);
  logic [3:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gapCnt <= '0;
    else if (pClkEn)        gapCnt <= '0;
    else if (gapCnt != 4'hF) gapCnt <= gapCnt + 1'b1;
  end

  // R2
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= 4'd7);

  // R3
  unity_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pClkEn) && ($past(ctlRdata[DIV_LSB +: 2]) == 2'b00)) |-> pClkEn);

  // R6
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pStb |-> (pClkEn && cpuReq));

  // R6
  ready_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdy == pStb);

  // R8
  fields_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pStb |-> (pWe == cpuWe && pAddr == cpuAddr));
endmodule

bind periph_clk_bridge pcb_chk #(.AW(AW), .DIV_LSB(DIV_LSB)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctlRdata (ctlRdata),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuAddr  (cpuAddr),
  .cpuRdy   (cpuRdy),
  .pClkEn   (pClkEn),
  .pStb     (pStb),
  .pWe      (pWe),
  .pAddr    (pAddr)
);

// File: tb/periph_clk_bridge_bench.sv
module periph_clk_bridge_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctlWe = 1'b0;
  logic [31:0]   ctlWdata = '0;
  logic [31:0]   ctlRdata;
  logic          cpuReq = 1'b0;
  logic          cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuRdy;
  logic [DW-1:0] cpuRdata;
  logic          pClkEn;
  logic          pStb;
  logic          pWe;
  logic [AW-1:0] pAddr;
  logic [DW-1:0] pWdata;
  logic [DW-1:0] pRdata;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // simple peripheral model: read data derived from the address
  assign pRdata = {24'hC0DE00, pAddr};

  periph_clk_bridge u_periph_clk_bridge (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlWdata(ctlWdata), .ctlRdata(ctlRdata),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdy(cpuRdy), .cpuRdata(cpuRdata), .pClkEn(pClkEn), .pStb(pStb), .pWe(pWe),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata)
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeDiv(input logic [31:0] val);
    step();
    ctlWe = 1'b1;
    ctlWdata = val;
    step();
    ctlWe = 1'b0;
    ctlWdata = '0;
  endtask

  task automatic syncPulse();
    for (int i = 0; i < 20; i++) begin
      step();
      #1;
      if (pClkEn) break;
    end
  endtask

  task automatic testReset();
    step();
    rstN = 1'b1;
    #1;
    chkEq("R1 enable after reset", 32'(pClkEn), 32'd1);
    chkEq("R1 ctl reads zero", ctlRdata, 32'd0);
    chkEq("R1 no ready idle", 32'(cpuRdy), 32'd0);
    chkEq("R1 no strobe idle", 32'(pStb), 32'd0);
  endtask

  task automatic testUnity();
    int highs = 0;
    for (int i = 0; i < 10; i++) begin
      step(); #1;
      if (pClkEn) highs++;
    end
    chkEq("R3 enable always high", 32'(highs), 32'd10);
    step();
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 8'h21;
    #1;
    chkEq("R3 same-cycle ready", 32'(cpuRdy), 32'd1);
    chkEq("R8 read data", cpuRdata, {24'hC0DE00, 8'h21});
    step();
    cpuReq = 1'b0;
    #1;
    chkEq("R8 read data zero when idle", cpuRdata, 32'd0);
  endtask

  task automatic testReadback();
    writeDiv(32'hFFFF_FFFF);
    #1;
    chkEq("R4 field at 20:19", ctlRdata, 32'h0018_0000);
    writeDiv(32'hFFEF_FFFF);
    #1;
    chkEq("R4 other bits ignored", ctlRdata, 32'h0008_0000);
    writeDiv(32'hFFE7_FFFF);
    #1;
    chkEq("R4 zero field", ctlRdata, 32'h0000_0000);
  endtask

  task automatic testPeriods();
    for (int code = 0; code < 4; code++) begin
      int n;
      writeDiv(32'(code) << 19);
      syncPulse();
      syncPulse();
      n = 0;
      for (int i = 0; i < 20; i++) begin
        step(); #1; n++;
        if (pClkEn) break;
      end
      chkEq("R2 pulse spacing", 32'(n), 32'd1 << code);
    end
  endtask

  task automatic testMidPeriodChange();
    writeDiv(32'h0018_0000);
    syncPulse(); syncPulse();
    step(); step();
    ctlWe = 1'b1; ctlWdata = 32'h0;
    step();
    ctlWe = 1'b0;
    #1;
    chkEq("R5 old period continues", 32'(pClkEn), 32'd0);
    for (int i = 4; i < 8; i++) begin
      step(); #1;
      chkEq("R5 old period low", 32'(pClkEn), 32'd0);
    end
    for (int i = 8; i < 11; i++) begin
      step(); #1;
      chkEq("R5 new ratio 1:1", 32'(pClkEn), 32'd1);
    end
  endtask

  task automatic testCoincident();
    step();
    ctlWe = 1'b1; ctlWdata = 32'h0010_0000;
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 8'h3C;
    #1;
    chkEq("R5 write on pulse cycle", 32'(pClkEn), 32'd1);
    chkEq("R7 ready with pending write", 32'(cpuRdy), 32'd1);
    chkEq("R8 read data coincident", cpuRdata, {24'hC0DE00, 8'h3C});
    step();
    ctlWe = 1'b0; cpuReq = 1'b0;
    #1;
    chkEq("R5 old-length pulse", 32'(pClkEn), 32'd1);
    chkEq("R4 new field", ctlRdata, 32'h0010_0000);
    for (int i = 2; i < 5; i++) begin
      step(); #1;
      chkEq("R5 1:4 gap", 32'(pClkEn), 32'd0);
    end
    step(); #1;
    chkEq("R5 1:4 pulse", 32'(pClkEn), 32'd1);
  endtask

  task automatic testLatency();
    writeDiv(32'h0018_0000);
    syncPulse(); syncPulse();
    for (int k = 0; k < 8; k++) begin
      int waitCyc = 0;
      int early = 0;
      syncPulse();
      for (int j = 0; j < k; j++) step();
      cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 8'(k);
      #1;
      for (int i = 0; i < 20; i++) begin
        if (cpuRdy) break;
        if (pStb) early++;
        step(); #1;
        waitCyc++;
      end
      chkEq("R7 wait at 1:8", 32'(waitCyc), 32'((8 - k) % 8));
      chkEq("R6 no strobe while waiting", 32'(early), 32'd0);
      chkEq("R8 read data at 1:8", cpuRdata, {24'hC0DE00, 8'(k)});
      step();
      cpuReq = 1'b0;
    end
  endtask

  task automatic testHeld();
    int rdys = 0;
    int misplaced = 0;
    writeDiv(32'h0008_0000);
    syncPulse(); syncPulse();
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 8'h77;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) step();
      #1;
      if (cpuRdy) rdys++;
      if (cpuRdy != (i % 2 == 0)) misplaced++;
    end
    chkEq("R9 one ready per pulse", 32'(rdys), 32'd4);
    chkEq("R9 ready only on pulses", 32'(misplaced), 32'd0);
    step();
    cpuReq = 1'b0;
  endtask

  task automatic testWrite();
    writeDiv(32'h0010_0000);
    syncPulse(); syncPulse();
    step();
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = 8'h55; cpuWdata = 32'hDEAD_BEEF;
    #1;
    for (int i = 0; i < 10; i++) begin
      if (cpuRdy) break;
      step(); #1;
    end
    chkEq("R8 write strobe", 32'(pStb), 32'd1);
    chkEq("R8 write flag", 32'(pWe), 32'd1);
    chkEq("R8 write address", 32'(pAddr), 32'h55);
    chkEq("R8 write data", pWdata, 32'hDEAD_BEEF);
    chkEq("R8 no read data on write", cpuRdata, 32'd0);
    step();
    cpuReq = 1'b0; cpuWe = 1'b0;
    #1;
    chkEq("R6 strobe drops with request", 32'(pStb), 32'd0);
  endtask

  initial begin
    repeat (3) step();
    testReset();
    testUnity();
    testReadback();
    testPeriods();
    testMidPeriodChange();
    testCoincident();
    testLatency();
    testHeld();
    testWrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule